// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a freshly powered SDRAM device into a usable state and then runs its periodic refresh timer. After reset it holds the command bus idle for the device's power-on settling time, then closes every bank, programs the mode register, runs a burst of auto-refresh commands, programs the mode register a second time, and finally issues a string of throw-away reads of address zero so the device settles. Between commands it keeps the bus idle for parameter-set recovery times covering precharge, mode-register and refresh recovery.

Periodic refresh is held off until the second mode-register load has been issued. From then on a prescaled timer raises a refresh request that stays high until the consumer acknowledges it. The timer starts at its fast rate. Once the memory size has been measured, a one-shot size report can slow the prescaler by half for small devices. The rest of the memory controller arbitrates the refresh request against normal traffic; read and write data transfers are not part of this block.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While rst_n is low, cmd is NOP (code 0), addr is 0, ref_req is 0 and init_done is 0.
- R2: After rst_n rises, cmd stays NOP for WAIT_CYCLES+2 rising edges (2 edges of reset synchronisation plus the power-on wait). The edge after that shows PRECHARGE ALL (code 1) with only addr bit AP_BIT (10) set. PRECHARGE ALL is issued exactly once.
- R3: The first MODE REGISTER SET (code 2) follows the precharge after T_RP idle cycles. It carries addr = MODE_VAL = 0x22, which selects CAS latency 2, burst length 4, sequential bursts and burst writes.
- R4: Exactly REF_GROUPS*REFS_PER_GROUP = 8 AUTO REFRESH commands (code 3) follow. The first comes T_MRD idle cycles after the first mode load, and each refresh is followed by T_RFC idle cycles.
- R5: A second MODE REGISTER SET with addr 0x22 follows the last refresh after T_RFC idle cycles, with no precharge between them.
- R6: NUM_READS = 10 READ commands (code 4) at addr 0 follow. The first comes T_MRD idle cycles after the second mode load, and each read is followed by T_RDGAP idle cycles.
- R7: init_done rises T_RDGAP+1 edges after the last READ and stays high. While it is high, cmd is NOP.
- R8: ref_req stays low until the second mode load. The timer starts on the next edge, and ref_req is set every DIV_FAST*REF_TICKS = 8*195 = 1560 cycles at the fast rate.
- R9: Once set, ref_req stays high until a rising edge that samples ref_ack high, and it is low on the following cycle. ref_ack has no effect while ref_req is low.
- R10: A size_valid pulse accepted after init_done selects the slow prescaler (DIV_SLOW = 16, a refresh period of 3120 cycles) when size_mb <= 32, and keeps the fast rate when size_mb > 32.
- R11: size_valid is ignored while init_done is low, and every size report after the first accepted one is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| size_valid | input | 1 | One-cycle strobe that reports the measured device size |
| size_mb | input | SIZE_W (10) | Measured device size in megabytes |
| ref_ack | input | 1 | Acknowledge that clears the refresh request |
| cmd | output | 3 | Command code: 0 NOP, 1 PRECHARGE ALL, 2 MRS, 3 REFRESH, 4 READ |
| addr | output | ADDR_W (13) | Address bus for the command |
| ref_req | output | 1 | Periodic refresh request, held until acknowledged |
| init_done | output | 1 | High once the power-up sequence has finished |

## Verification
Each command is registered, so it shows on cmd and addr one edge after the sequencer decides it. The first command arrives WAIT_CYCLES+3 edges after reset release. The bench's behavioural model keeps a queue of the expected command for every edge, counts the refresh timer from the edge after the second mode load, and is compared with the outputs at each falling clock edge. ref_req clears on the edge that samples ref_ack, and a size report changes the prescaler limit from the edge after it is accepted. Directed checks therefore sample one cycle after each stimulus, and they measure the gaps between request rises in whole cycles against 1560 and 3120.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    CMD_NOP       = 3'd0,
    CMD_PRECHARGE = 3'd1,
    CMD_MRS       = 3'd2,
    CMD_REFRESH   = 3'd3,
    CMD_READ      = 3'd4
  } sdram_cmd_e;

  typedef enum logic [2:0] {
    PH_PRE,
    PH_MRS1,
    PH_REF,
    PH_MRS2,
    PH_READ,
    PH_DONE
  } init_phase_e;

endpackage

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W         = 13,
  parameter int WAIT_CYCLES    = 10000,
  parameter int T_RP           = 2,
  parameter int T_MRD          = 2,
  parameter int T_RFC          = 4,
  parameter int T_RDGAP        = 1,
  parameter int REF_GROUPS     = 2,
  parameter int REFS_PER_GROUP = 4,
  parameter int NUM_READS      = 10,
  parameter int MODE_VAL       = 34,
  parameter int AP_BIT         = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  output sdram_cmd_e        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              ref_en,
  output logic              init_done
);

  localparam int NUM_REF = REF_GROUPS * REFS_PER_GROUP;
  localparam int GAP_W   = $clog2(WAIT_CYCLES + T_RP + T_MRD + T_RFC + T_RDGAP + 2);
  localparam int REP_MAX = (NUM_REF > NUM_READS) ? NUM_REF : NUM_READS;
  localparam int REP_W   = $clog2(REP_MAX + 1);

  localparam logic [GAP_W-1:0]  GAP_WAIT  = GAP_W'(WAIT_CYCLES);
  localparam logic [GAP_W-1:0]  GAP_RP    = GAP_W'(T_RP);
  localparam logic [GAP_W-1:0]  GAP_MRD   = GAP_W'(T_MRD);
  localparam logic [GAP_W-1:0]  GAP_RFC   = GAP_W'(T_RFC);
  localparam logic [GAP_W-1:0]  GAP_RD    = GAP_W'(T_RDGAP);
  localparam logic [REP_W-1:0]  LAST_REF  = REP_W'(NUM_REF - 1);
  localparam logic [REP_W-1:0]  LAST_READ = REP_W'(NUM_READS - 1);
  localparam logic [ADDR_W-1:0] ADDR_MODE = ADDR_W'(MODE_VAL);
  localparam logic [ADDR_W-1:0] ADDR_ALL  = ADDR_W'(1) << AP_BIT;

  init_phase_e       phase_q, phase_d;
  logic [GAP_W-1:0]  gap_q,   gap_d;
  logic [REP_W-1:0]  rep_q,   rep_d;
  sdram_cmd_e        cmd_q,   cmd_d;
  logic [ADDR_W-1:0] addr_q,  addr_d;
  logic              en_q,    en_d;
  logic              done_q,  done_d;
  logic              issue;

  // A new command may leave only once the recovery gap has run out.
  assign issue = (gap_q == '0);

  always_comb begin
    phase_d = phase_q;
    gap_d   = gap_q;
    rep_d   = rep_q;
    cmd_d   = CMD_NOP;
    addr_d  = '0;
    en_d    = en_q;
    done_d  = done_q;
    if (!issue) begin
      gap_d = gap_q - 1'b1;
    end else begin
      unique case (phase_q)
        PH_PRE: begin
          cmd_d   = CMD_PRECHARGE;
          addr_d  = ADDR_ALL;
          gap_d   = GAP_RP;
          phase_d = PH_MRS1;
        end
        PH_MRS1: begin
          cmd_d   = CMD_MRS;
          addr_d  = ADDR_MODE;
          gap_d   = GAP_MRD;
          rep_d   = '0;
          phase_d = PH_REF;
        end
        PH_REF: begin
          cmd_d = CMD_REFRESH;
          gap_d = GAP_RFC;
          if (rep_q == LAST_REF) begin
            rep_d   = '0;
            phase_d = PH_MRS2;
          end else begin
            rep_d = rep_q + 1'b1;
          end
        end
        PH_MRS2: begin
          cmd_d   = CMD_MRS;
          addr_d  = ADDR_MODE;
          gap_d   = GAP_MRD;
          rep_d   = '0;
          en_d    = 1'b1;
          phase_d = PH_READ;
        end
        PH_READ: begin
          cmd_d = CMD_READ;
          gap_d = GAP_RD;
          if (rep_q == LAST_READ) begin
            rep_d   = '0;
            phase_d = PH_DONE;
          end else begin
            rep_d = rep_q + 1'b1;
          end
        end
        default: begin
          done_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_PRE;
      gap_q   <= GAP_WAIT;
      rep_q   <= '0;
      cmd_q   <= CMD_NOP;
      addr_q  <= '0;
      en_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      gap_q   <= gap_d;
      rep_q   <= rep_d;
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      en_q    <= en_d;
      done_q  <= done_d;
    end
  end

  assign cmd       = cmd_q;
  assign addr      = addr_q;
  assign ref_en    = en_q;
  assign init_done = done_q;

endmodule

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int REF_TICKS = 195,
  parameter int DIV_FAST  = 8,
  parameter int DIV_SLOW  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic slow,
  input  logic ack,
  output logic req
);

  localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int PW      = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;
  localparam int TW      = (REF_TICKS > 1) ? $clog2(REF_TICKS) : 1;
  localparam logic [PW-1:0] LIM_FAST = PW'(DIV_FAST - 1);
  localparam logic [PW-1:0] LIM_SLOW = PW'(DIV_SLOW - 1);
  localparam logic [TW-1:0] LAST_TICK = TW'(REF_TICKS - 1);

  logic [PW-1:0] presc_q, presc_d;
  logic [TW-1:0] tick_q,  tick_d;
  logic          req_q,   req_d;
  logic [PW-1:0] limit;
  logic          tick, wrap;

  assign limit = slow ? LIM_SLOW : LIM_FAST;
  assign tick  = enable && (presc_q >= limit);
  assign wrap  = tick && (tick_q == LAST_TICK);

  always_comb begin
    presc_d = tick ? '0 : presc_q + 1'b1;
    tick_d  = wrap ? '0 : tick_q + 1'b1;
    if (wrap) begin
      req_d = 1'b1;
    end else if (ack) begin
      req_d = 1'b0;
    end else begin
      req_d = req_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      tick_q  <= '0;
      req_q   <= 1'b0;
    end else begin
      if (enable) begin
        presc_q <= presc_d;
      end
      if (tick) begin
        tick_q <= tick_d;
      end
      req_q <= req_d;
    end
  end

  assign req = req_q;

endmodule

// File: rtl/sdram_rate_sel.sv
module sdram_rate_sel #(
  parameter int SIZE_W   = 10,
  parameter int SMALL_MB = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              size_valid,
  input  logic [SIZE_W-1:0] size_mb,
  input  logic              init_done,
  output logic              slow
);

  localparam logic [SIZE_W-1:0] SMALL_LIM = SIZE_W'(SMALL_MB);

  logic lock_q, slow_q, accept;

  // Only the first report after start-up counts.
  assign accept = size_valid && init_done && !lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      slow_q <= 1'b0;
    end else if (accept) begin
      lock_q <= 1'b1;
      slow_q <= (size_mb <= SMALL_LIM);
    end
  end

  assign slow = slow_q;

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W         = 13,
  parameter int SIZE_W         = 10,
  parameter int WAIT_CYCLES    = 10000,
  parameter int T_RP           = 2,
  parameter int T_MRD          = 2,
  parameter int T_RFC          = 4,
  parameter int T_RDGAP        = 1,
  parameter int REF_GROUPS     = 2,
  parameter int REFS_PER_GROUP = 4,
  parameter int NUM_READS      = 10,
  parameter int MODE_VAL       = 34,
  parameter int AP_BIT         = 10,
  parameter int REF_TICKS      = 195,
  parameter int DIV_FAST       = 8,
  parameter int DIV_SLOW       = 16,
  parameter int SMALL_MB       = 32,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              size_valid,
  input  logic [SIZE_W-1:0] size_mb,
  input  logic              ref_ack,
  output logic [2:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              ref_req,
  output logic              init_done
);

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  sdram_cmd_e             cmd_e;
  logic                   ref_en, slow, done;

  // Assertion is asynchronous; release is retimed onto clk.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  sdram_init_fsm #(
    .ADDR_W(ADDR_W), .WAIT_CYCLES(WAIT_CYCLES), .T_RP(T_RP), .T_MRD(T_MRD),
    .T_RFC(T_RFC), .T_RDGAP(T_RDGAP), .REF_GROUPS(REF_GROUPS),
    .REFS_PER_GROUP(REFS_PER_GROUP), .NUM_READS(NUM_READS),
    .MODE_VAL(MODE_VAL), .AP_BIT(AP_BIT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .cmd(cmd_e), .addr(addr),
    .ref_en(ref_en), .init_done(done)
  );

  sdram_rate_sel #(.SIZE_W(SIZE_W), .SMALL_MB(SMALL_MB)) u_rate (
    .clk(clk), .rst_n(rst_int_n), .size_valid(size_valid),
    .size_mb(size_mb), .init_done(done), .slow(slow)
  );

  sdram_ref_timer #(
    .REF_TICKS(REF_TICKS), .DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)
  ) u_timer (
    .clk(clk), .rst_n(rst_int_n), .enable(ref_en), .slow(slow),
    .ack(ref_ack), .req(ref_req)
  );

  assign cmd       = cmd_e;
  assign init_done = done;

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int ADDR_W  = 13,
  parameter int MODE_VAL = 34,
  parameter int AP_BIT  = 10,
  parameter int NUM_REF = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic              ref_req,
  input logic              ref_ack,
  input logic              init_done
);

  localparam int RW = $clog2(NUM_REF + 2);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(MODE_VAL);
  localparam logic [ADDR_W-1:0] A_ALL  = ADDR_W'(1) << AP_BIT;
  localparam logic [RW-1:0]     N_REF  = RW'(NUM_REF);

  logic [1:0]    mrs_seen;
  logic [RW-1:0] ref_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrs_seen <= '0;
      ref_seen <= '0;
    end else begin
      if (cmd == 3'd2 && mrs_seen != 2'd3) mrs_seen <= mrs_seen + 1'b1;
      if (cmd == 3'd3 && ref_seen <= N_REF) ref_seen <= ref_seen + 1'b1;
    end
  end

  assert_pre_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd1) |-> (addr == A_ALL && mrs_seen == 2'd0 && ref_seen == '0));

  assert_mode_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd2) |-> (addr == A_MODE));

  assert_ref_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd3) |-> (mrs_seen == 2'd1 && ref_seen < N_REF));

  assert_second_mrs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd2 && mrs_seen == 2'd1) |-> (ref_seen == N_REF));

  assert_dummy_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd4) |-> (addr == '0 && mrs_seen == 2'd2 && !init_done));

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cmd == 3'd0));

  assert_no_early_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_seen < 2'd2) |-> !ref_req);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_ack) |=> ref_req);

endmodule

bind sdram_pwrup_seq sdram_init_chk #(
  .ADDR_W(ADDR_W), .MODE_VAL(MODE_VAL), .AP_BIT(AP_BIT),
  .NUM_REF(REF_GROUPS * REFS_PER_GROUP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .ref_req(ref_req),
  .ref_ack(ref_ack), .init_done(init_done)
);

// File: tb/tb_sdram_pwrup_seq.sv
`timescale 1ns/1ps
module tb_sdram_pwrup_seq;

  localparam int WAITC = 10000, TRP = 2, TMRD = 2, TRFC = 4, TRD = 1;
  localparam int NREF = 8, NRD = 10, MODEV = 34, TICKS = 195;

  logic       clk, rst_n, size_valid, ref_ack;
  logic [9:0] size_mb;
  logic [2:0] cmd;
  logic [12:0] addr;
  logic       ref_req, init_done;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0, cmp_on = 0;

  sdram_pwrup_seq dut (
    .clk(clk), .rst_n(rst_n), .size_valid(size_valid), .size_mb(size_mb),
    .ref_ack(ref_ack), .cmd(cmd), .addr(addr), .ref_req(ref_req),
    .init_done(init_done)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // Behavioural reference: expected command per edge plus refresh timing.
  int q_cmd[$], q_addr[$], q_en[$];
  int m_cmd, m_addr, m_presc, m_tick;
  bit m_done, m_en, m_req, m_slow, m_lock;

  task automatic push(int c, int a, int e, int n_idle);
    q_cmd.push_back(c); q_addr.push_back(a); q_en.push_back(e);
    for (int i = 0; i < n_idle; i++) begin
      q_cmd.push_back(0); q_addr.push_back(0); q_en.push_back(0);
    end
  endtask

  task automatic reset_model();
    q_cmd.delete(); q_addr.delete(); q_en.delete();
    push(0, 0, 0, WAITC + 1);
    push(1, 1 << 10, 0, TRP);
    push(2, MODEV, 0, TMRD);
    for (int i = 0; i < NREF; i++) push(3, 0, 0, TRFC);
    push(2, MODEV, 1, TMRD);
    for (int i = 0; i < NRD; i++) push(4, 0, 0, TRD);
    m_cmd = 0; m_addr = 0; m_presc = 0; m_tick = 0;
    m_done = 0; m_en = 0; m_req = 0; m_slow = 0; m_lock = 0;
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      bit was_done, was_en, was_slow, wrap;
      was_done = m_done; was_en = m_en; was_slow = m_slow; wrap = 0;
      if (was_en) begin
        if (m_presc >= (was_slow ? 15 : 7)) begin
          m_presc = 0;
          if (m_tick == TICKS - 1) begin m_tick = 0; wrap = 1; end
          else m_tick++;
        end else m_presc++;
      end
      if (wrap) m_req = 1;
      else if (ref_ack) m_req = 0;
      if (size_valid && was_done && !m_lock) begin
        m_lock = 1; m_slow = (size_mb <= 32);
      end
      if (q_cmd.size() > 0) begin
        m_cmd = q_cmd.pop_front(); m_addr = q_addr.pop_front();
        if (q_en.pop_front() != 0) m_en = 1;
      end else begin
        m_cmd = 0; m_addr = 0; m_done = 1;
      end
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic string cmd_tag(int c);
    case (c)
      1: return "R2";
      2: return m_en ? "R5" : "R3";
      3: return "R4";
      4: return "R6";
      default: return m_done ? "R7" : "R2";
    endcase
  endfunction

  int n_pre = 0, n_mrs = 0, n_ref = 0, n_rd = 0;
  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      string t;
      t = cmd_tag(m_cmd);
      checks++;
      if (int'(cmd) != m_cmd || int'(addr) != m_addr || init_done != m_done || ref_req != m_req) begin
        errors++;
        if (int'(cmd) != m_cmd) $display("FAIL %s cmd: actual %0d expected %0d (cycle %0d)", t, cmd, m_cmd, cyc);
        if (int'(addr) != m_addr) $display("FAIL %s addr: actual %0d expected %0d (cycle %0d)", t, addr, m_addr, cyc);
        if (init_done != m_done) $display("FAIL R7 init_done: actual %0d expected %0d (cycle %0d)", init_done, m_done, cyc);
        if (ref_req != m_req) $display("FAIL %s ref_req: actual %0d expected %0d (cycle %0d)", m_slow ? "R10" : "R8", ref_req, m_req, cyc);
      end
      case (cmd)
        3'd1: n_pre++;
        3'd2: n_mrs++;
        3'd3: n_ref++;
        3'd4: n_rd++;
        default: ;
      endcase
    end
  end

  int last_rise = 0;
  int gap_seen = 0;

  // Waits for a request, measures the gap since the previous one,
  // holds it unacknowledged for 'hold' cycles, then acknowledges it.
  task automatic serve(int hold);
    while (!ref_req) @(negedge clk);
    gap_seen = cyc - last_rise;
    last_rise = cyc;
    repeat (hold) @(negedge clk);
    check("R9", "ref_req held without ack", ref_req, 1);
    ref_ack = 1;
    @(negedge clk);
    ref_ack = 0;
    check("R9", "ref_req after ack", ref_req, 0);
    @(negedge clk);
    ref_ack = 1;
    @(negedge clk);
    ref_ack = 0;
    check("R9", "ack while idle has no effect", ref_req, 0);
  endtask

  task automatic do_reset();
    cmp_on = 0;
    rst_n = 0;
    reset_model();
    n_pre = 0; n_mrs = 0; n_ref = 0; n_rd = 0;
    repeat (4) @(negedge clk);
    check("R1", "cmd in reset", cmd, 0);
    check("R1", "addr in reset", addr, 0);
    check("R1", "ref_req in reset", ref_req, 0);
    check("R1", "init_done in reset", init_done, 0);
    rst_n = 1;
    cmp_on = 1;
  endtask

  task automatic pulse_size(int mb);
    size_mb = 10'(mb); size_valid = 1;
    @(negedge clk);
    size_valid = 0;
  endtask

  task automatic wait_done();
    while (!init_done) @(negedge clk);
    check("R2", "precharge count", n_pre, 1);
    check("R5", "mode load count", n_mrs, 2);
    check("R4", "refresh count", n_ref, NREF);
    check("R6", "dummy read count", n_rd, NRD);
    check("R8", "no request during init", ref_req, 0);
  endtask

  initial begin
    rst_n = 0; size_valid = 0; size_mb = 0; ref_ack = 0;
    // Run 1: early report ignored, large device stays fast, later report ignored.
    do_reset();
    repeat (100) @(negedge clk);
    pulse_size(16);                         // R11: before init_done
    wait_done();
    last_rise = cyc;
    serve(3);
    serve(20);
    check("R8", "fast refresh period", gap_seen, 8 * TICKS);
    pulse_size(64);                         // R10: above the limit
    serve(3);
    serve(3);
    check("R10", "large device keeps fast period", gap_seen, 8 * TICKS);
    pulse_size(16);                         // R11: after lock
    serve(3);
    serve(3);
    check("R11", "second report ignored", gap_seen, 8 * TICKS);
    // Run 2: boundary size selects the slow rate.
    do_reset();
    wait_done();
    pulse_size(32);
    last_rise = cyc;
    serve(3);
    serve(3);
    serve(3);
    check("R10", "slow refresh period at 32 MB", gap_seen, 16 * TICKS);
    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule